// File: doc/BRIEF.md
# Pattern Pulse-Width Trigger Qualifier

This block watches a small group of synchronous digital channels and forms one pattern condition from them. Each channel is set to require a high level, require a low level, or be ignored. The pattern holds only when every channel that is not ignored matches its setting. A polarity control picks which state of the pattern is timed: the stretch where it holds, or the stretch where it does not. The length of that stretch is counted in clock cycles.

The measured length is compared with one or two thresholds. Four comparison modes are available. Three of them decide once the stretch has ended: longer than T1, shorter than T1, or strictly between T1 and T2. The fourth mode is a timeout. It fires while the stretch is still running, as soon as the length passes T1. A qualifying event becomes a single-cycle pulse on the trigger output only if an external gate input is at its programmed active level on the deciding cycle.

A stretch that is already running when reset is released, or when the block is enabled, is never measured. Timing starts at the next fresh entry into the selected state.

Top module: `pattern_width_trigger`

## Requirements
- R1: Channel i takes its setting from `chan_cond[2i+1:2i]`. 2'b01 requires `chan_in[i]`=1, 2'b10 requires `chan_in[i]`=0, and 2'b00 or 2'b11 ignore the channel. The pattern holds when all non-ignored channels match.
- R2: With `pol_sel`=1 the timed state is "pattern holds"; with `pol_sel`=0 it is "pattern does not hold".
- R3: The duration D of a stretch is the number of rising clock edges that sample the timed state, counted from its entry edge. For modes 0 to 2, the decision is taken on the first edge that samples the state left (the closing edge). A trigger appears as `trig_out`=1 for exactly the one cycle that follows that edge.
- R4: Mode 2'b00 (longer) triggers at the close when D > T1.
- R5: Mode 2'b01 (shorter) triggers at the close when D < T1.
- R6: Mode 2'b10 (window) triggers at the close when T1 < D < T2, with both bounds strict.
- R7: Mode 2'b11 (timeout) triggers on the edge where the running duration first reaches T1+1, which is the entry edge when T1=0. It fires at most once per stretch and never at the close.
- R8: An event produces a trigger only if `gate_in` equals `gate_active_high` on the deciding edge. Otherwise the event is dropped and is not retried.
- R9: The duration count saturates at 2^CNT_W-1 and does not wrap.
- R10: A stretch already running at reset release or when `enable` rises is ignored. While `enable`=0 no stretch is opened and a running one is abandoned.
- R11: During reset and immediately after it, `trig_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Allows stretches to be opened and measured |
| chan_in | input | NUM_CH | Synchronous channel levels |
| chan_cond | input | 2*NUM_CH | Per-channel setting, two bits per channel |
| pol_sel | input | 1 | 1: time the matching state; 0: time the non-matching state |
| mode_sel | input | 2 | Comparison mode: longer, shorter, window, timeout |
| thr_t1 | input | CNT_W | Threshold T1 in cycles |
| thr_t2 | input | CNT_W | Upper window bound T2 in cycles |
| gate_in | input | 1 | External trigger gate |
| gate_active_high | input | 1 | 1: gate is active when high; 0: active when low |
| trig_out | output | 1 | Single-cycle trigger pulse |

## Verification
The gate and the closing of a stretch can change in the same cycle, and the decision depends on which gate value that edge samples. The bench provokes this by changing `gate_in` on the same falling edge on which the channels leave the timed state. It runs two cases. In the first, a gate that was active goes inactive at the close, and no pulse must follow. In the second, an inactive gate becomes active at the close, and a pulse must follow in exactly the cycle after the closing edge. The timeout with T1=0 similarly puts stretch entry and the firing decision on one edge; the bench expects that pulse at the first sample point.

// File: rtl/pwt_pkg.sv
// Shared encodings for the pattern pulse-width trigger qualifier.
// Assumes: the two-bit channel settings and two-bit mode codes below are
// the values software writes onto the configuration pins.
package pwt_pkg;

    // Per-channel level requirement
    typedef enum logic [1:0] {
        COND_ANY_A = 2'b00,
        COND_HIGH  = 2'b01,
        COND_LOW   = 2'b10,
        COND_ANY_B = 2'b11
    } ch_cond_e;

    // Duration comparison selector
    typedef enum logic [1:0] {
        CMP_LONGER  = 2'b00,
        CMP_SHORTER = 2'b01,
        CMP_BETWEEN = 2'b10,
        CMP_TIMEOUT = 2'b11
    } cmp_mode_e;

    // Edge events reported by the interval tracker
    typedef struct packed {
        logic open;   // entry edge of a fresh stretch
        logic grow;   // stretch continues on this edge
        logic close;  // first edge with the timed state gone
    } span_ev_t;

endpackage

// File: rtl/pwt_pattern_match.sv
// Combines per-channel level requirements into one pattern flag.
// Assumes: channel inputs are already synchronous to clk; clk and rst_n
// are used only by the embedded checks.
module pwt_pattern_match
    import pwt_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     ch_val,
    input  logic [2*NUM_CH-1:0]   ch_cond,
    output logic                  match
);

    logic [NUM_CH-1:0] ch_ok;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ch_cond_e cond_i;
        assign cond_i = ch_cond_e'(ch_cond[2*i +: 2]);

        // Decide whether this channel satisfies its own requirement
        always_comb begin
            if (cond_i == COND_HIGH)
                ch_ok[i] = ch_val[i];
            else if (cond_i == COND_LOW)
                ch_ok[i] = ~ch_val[i];
            else
                ch_ok[i] = 1'b1;
        end

        // R1
        chan_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((cond_i == COND_HIGH && !ch_val[i]) ||
             (cond_i == COND_LOW  &&  ch_val[i])) |-> !match);
    end

    // Logical AND across all channels
    assign match = &ch_ok;

endmodule

// File: rtl/pwt_interval_tracker.sv
// Follows entries into and exits from the timed state and counts the
// stretch length in cycles with a saturating counter.
// Assumes: `level` is 1 while the timed state is present; the first edge
// after reset only learns the current level and never opens a stretch.
module pwt_interval_tracker
    import pwt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              level,
    output span_ev_t          ev,
    output logic [CNT_W-1:0]  dur_next,
    output logic [CNT_W-1:0]  dur_done
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             primed;
    logic             level_q;
    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;

    // Saturating increment of the running length
    assign cnt_inc = (cnt == CNT_MAX) ? CNT_MAX : cnt + CNT_ONE;

    // Classify the current edge
    always_comb begin
        ev.open  = enable && primed && level && !level_q;
        ev.grow  = enable && armed  && level &&  level_q;
        ev.close = enable && armed  && !level;
    end

    // Length including this edge, and length of a stretch that ends here
    assign dur_next = ev.open ? CNT_ONE : cnt_inc;
    assign dur_done = cnt;

    // Track previous level, arming and length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed  <= 1'b0;
            level_q <= 1'b0;
            armed   <= 1'b0;
            cnt     <= '0;
        end else begin
            primed  <= 1'b1;
            level_q <= level;
            if (!enable) begin
                armed <= 1'b0;
            end else if (ev.open) begin
                armed <= 1'b1;
                cnt   <= CNT_ONE;
            end else if (ev.grow) begin
                cnt   <= cnt_inc;
            end else if (ev.close) begin
                armed <= 1'b0;
            end
        end
    end

    // R9
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.grow && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    // R10
    no_arm_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |=> !armed);

    // R10
    arm_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !armed);

endmodule

// File: rtl/pwt_decider.sv
// Applies the selected comparison to the stretch length, qualifies the
// result with the external gate and registers a one-cycle trigger.
// Assumes: events come from pwt_interval_tracker on the same edge.
module pwt_decider
    import pwt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic [CNT_W-1:0]  thr_t1,
    input  logic [CNT_W-1:0]  thr_t2,
    input  span_ev_t          ev,
    input  logic [CNT_W-1:0]  dur_next,
    input  logic [CNT_W-1:0]  dur_done,
    input  logic              gate_in,
    input  logic              gate_active_high,
    output logic              trig
);

    cmp_mode_e mode;
    logic      gate_ok;
    logic      close_hit;
    logic      timeout_hit;
    logic      fired;
    logic      fired_live;

    assign mode    = cmp_mode_e'(mode_sel);
    assign gate_ok = (gate_in == gate_active_high);

    // Comparison of a finished stretch against the thresholds
    always_comb begin
        case (mode)
            CMP_LONGER:  close_hit = dur_done > thr_t1;
            CMP_SHORTER: close_hit = dur_done < thr_t1;
            CMP_BETWEEN: close_hit = (dur_done > thr_t1) && (dur_done < thr_t2);
            default:     close_hit = 1'b0;
        endcase
    end

    // Timeout fires once per stretch while it is still running
    assign fired_live  = fired && !ev.open;
    assign timeout_hit = (mode == CMP_TIMEOUT) && (ev.open || ev.grow) &&
                         !fired_live && (dur_next > thr_t1);

    // Remember that the current stretch has already produced its timeout
    always_ff @(posedge clk) begin
        if (!rst_n)
            fired <= 1'b0;
        else if (timeout_hit)
            fired <= 1'b1;
        else if (ev.open)
            fired <= 1'b0;
    end

    // Register the gated trigger pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig <= 1'b0;
        else
            trig <= gate_ok && (timeout_hit || (ev.close && close_hit));
    end

    // R8
    gate_sampled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(gate_in == gate_active_high));

    // R7
    timeout_no_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CMP_TIMEOUT && ev.close) |=> !trig);

    // R7
    timeout_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && ev.grow) |=> !trig);

endmodule

// File: rtl/pattern_width_trigger.sv
// Top of the pattern pulse-width trigger qualifier: pattern match,
// polarity selection, interval tracking and gated decision.
// Assumes: all inputs are synchronous to clk; configuration changes are
// made while no stretch is being timed.
module pattern_width_trigger
    import pwt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic [NUM_CH-1:0]     chan_in,
    input  logic [2*NUM_CH-1:0]   chan_cond,
    input  logic                  pol_sel,
    input  logic [1:0]            mode_sel,
    input  logic [CNT_W-1:0]      thr_t1,
    input  logic [CNT_W-1:0]      thr_t2,
    input  logic                  gate_in,
    input  logic                  gate_active_high,
    output logic                  trig_out
);

    logic             pat_match;
    logic             timed_level;
    span_ev_t         span_ev;
    logic [CNT_W-1:0] dur_next;
    logic [CNT_W-1:0] dur_done;

    pwt_pattern_match #(.NUM_CH(NUM_CH)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .ch_val  (chan_in),
        .ch_cond (chan_cond),
        .match   (pat_match)
    );

    // Select whether the matching or the non-matching state is timed
    assign timed_level = (pat_match == pol_sel);

    pwt_interval_tracker #(.CNT_W(CNT_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .level    (timed_level),
        .ev       (span_ev),
        .dur_next (dur_next),
        .dur_done (dur_done)
    );

    pwt_decider #(.CNT_W(CNT_W)) u_decide (
        .clk              (clk),
        .rst_n            (rst_n),
        .mode_sel         (mode_sel),
        .thr_t1           (thr_t1),
        .thr_t2           (thr_t2),
        .ev               (span_ev),
        .dur_next         (dur_next),
        .dur_done         (dur_done),
        .gate_in          (gate_in),
        .gate_active_high (gate_active_high),
        .trig             (trig_out)
    );

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !trig_out);

endmodule

// File: tb/pattern_width_trigger_bench.sv
module pattern_width_trigger_bench;

    localparam int NCH = 4;
    localparam int CW  = 6;

    typedef struct packed {
        logic [7:0] cond;
        logic [3:0] hitv;
        logic [3:0] missv;
        logic       pol;
        logic [1:0] mode;
        logic [5:0] t1;
        logic [5:0] t2;
        logic [7:0] dur;
        logic       gin;
        logic       ghi;
        logic [7:0] exp_pos;   // 0: no pulse expected
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{8'h55, 4'hF, 4'hE, 1'b1, 2'd0, 6'd5, 6'd0, 8'd6,  1'b1, 1'b1, 8'd7}, // R4 above
        '{8'h55, 4'hF, 4'hE, 1'b1, 2'd0, 6'd5, 6'd0, 8'd5,  1'b1, 1'b1, 8'd0}, // R4 equal
        '{8'h55, 4'hF, 4'hE, 1'b1, 2'd1, 6'd5, 6'd0, 8'd4,  1'b1, 1'b1, 8'd5}, // R5 below
        '{8'h55, 4'hF, 4'hE, 1'b1, 2'd1, 6'd5, 6'd0, 8'd5,  1'b1, 1'b1, 8'd0}, // R5 equal
        '{8'h55, 4'hF, 4'hE, 1'b1, 2'd2, 6'd3, 6'd6, 8'd4,  1'b1, 1'b1, 8'd5}, // R6 inside
        '{8'h55, 4'hF, 4'hE, 1'b1, 2'd2, 6'd3, 6'd6, 8'd3,  1'b1, 1'b1, 8'd0}, // R6 at T1
        '{8'h55, 4'hF, 4'hE, 1'b1, 2'd2, 6'd3, 6'd6, 8'd6,  1'b1, 1'b1, 8'd0}, // R6 at T2
        '{8'h55, 4'hF, 4'hE, 1'b1, 2'd2, 6'd3, 6'd6, 8'd5,  1'b1, 1'b1, 8'd6}, // R6 top inside
        '{8'h55, 4'hF, 4'hE, 1'b1, 2'd3, 6'd4, 6'd0, 8'd10, 1'b1, 1'b1, 8'd5}, // R7 mid-stretch
        '{8'h55, 4'hF, 4'hE, 1'b1, 2'd3, 6'd4, 6'd0, 8'd4,  1'b1, 1'b1, 8'd0}, // R7 not reached
        '{8'h55, 4'hF, 4'hE, 1'b1, 2'd3, 6'd0, 6'd0, 8'd3,  1'b1, 1'b1, 8'd1}, // R7 T1=0 entry
        '{8'h87, 4'h2, 4'hF, 1'b0, 2'd0, 6'd2, 6'd0, 8'd3,  1'b1, 1'b1, 8'd4}, // R1 R2 mixed
        '{8'hAA, 4'h0, 4'h4, 1'b1, 2'd0, 6'd1, 6'd0, 8'd2,  1'b1, 1'b1, 8'd3}, // R1 all low
        '{8'h55, 4'hF, 4'hE, 1'b1, 2'd0, 6'd1, 6'd0, 8'd3,  1'b0, 1'b0, 8'd4}, // R8 low active
        '{8'h55, 4'hF, 4'hE, 1'b1, 2'd0, 6'd1, 6'd0, 8'd3,  1'b1, 1'b0, 8'd0}, // R8 blocked
        '{8'h55, 4'hF, 4'hE, 1'b1, 2'd0, 6'd1, 6'd0, 8'd3,  1'b0, 1'b1, 8'd0}, // R8 blocked
        '{8'h55, 4'hF, 4'hE, 1'b0, 2'd1, 6'd9, 6'd0, 8'd3,  1'b1, 1'b1, 8'd4}  // R2 false time
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enable = 1'b1;
    logic [NCH-1:0]  chan_in = '0;
    logic [7:0]      chan_cond = 8'h55;
    logic            pol_sel = 1'b1;
    logic [1:0]      mode_sel = 2'd0;
    logic [CW-1:0]   thr_t1 = '0;
    logic [CW-1:0]   thr_t2 = '0;
    logic            gate_in = 1'b1;
    logic            gate_active_high = 1'b1;
    logic            trig_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    pattern_width_trigger #(.NUM_CH(NCH), .CNT_W(CW)) u_pattern_width_trigger (
        .clk              (clk),
        .rst_n            (rst_n),
        .enable           (enable),
        .chan_in          (chan_in),
        .chan_cond        (chan_cond),
        .pol_sel          (pol_sel),
        .mode_sel         (mode_sel),
        .thr_t1           (thr_t1),
        .thr_t2           (thr_t2),
        .gate_in          (gate_in),
        .gate_active_high (gate_active_high),
        .trig_out         (trig_out)
    );

    task automatic check(input string req, input int np, input int fp, input int exp_pos);
        bit ok;
        n_checks++;
        ok = (exp_pos == 0) ? (np == 0) : (np == 1 && fp == exp_pos);
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: pulses=%0d first=%0d, expected pulses=%0d at %0d",
                     req, np, fp, (exp_pos == 0) ? 0 : 1, exp_pos);
        end
    endtask

    task automatic setup(input logic [7:0] c, input logic p, input logic [1:0] m,
                         input int t1, input int t2, input logic gi, input logic gh,
                         input logic [3:0] idlev);
        @(negedge clk);
        chan_cond = c; pol_sel = p; mode_sel = m;
        thr_t1 = CW'(t1); thr_t2 = CW'(t2);
        gate_in = gi; gate_active_high = gh;
        chan_in = idlev;
        repeat (3) @(negedge clk);
    endtask

    // Drive the timed state for dur edges, then leave it; sample at falling edges
    task automatic run_interval(input logic [3:0] selv, input logic [3:0] idlev,
                                input int dur, input bit flip_gate,
                                output int np, output int fp);
        np = 0; fp = 0;
        @(negedge clk);
        chan_in = selv;
        for (int i = 1; i <= dur + 6; i++) begin
            @(negedge clk);
            if (trig_out) begin
                np++;
                if (fp == 0) fp = i;
            end
            if (i == dur) begin
                chan_in = idlev;
                if (flip_gate) gate_in = ~gate_in;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int np, fp;
        logic [3:0] sv, iv;

        // R11: reset state
        repeat (3) @(negedge clk);
        n_checks++;
        if (trig_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R11: trig_out=%b during reset, expected 0", trig_out);
        end
        rst_n = 1'b1;
        chan_in = 4'hE;
        @(negedge clk);
        n_checks++;
        if (trig_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R11: trig_out=%b after reset, expected 0", trig_out);
        end

        // Table walk (R3 timing applies to every entry)
        for (int v = 0; v < NV; v++) begin
            sv = VECS[v].pol ? VECS[v].hitv : VECS[v].missv;
            iv = VECS[v].pol ? VECS[v].missv : VECS[v].hitv;
            setup(VECS[v].cond, VECS[v].pol, VECS[v].mode, int'(VECS[v].t1),
                  int'(VECS[v].t2), VECS[v].gin, VECS[v].ghi, iv);
            run_interval(sv, iv, int'(VECS[v].dur), 1'b0, np, fp);
            check($sformatf("R3 vector %0d", v), np, fp, int'(VECS[v].exp_pos));
        end

        // R9: long stretch still compares as long
        setup(8'h55, 1'b1, 2'd0, 62, 0, 1'b1, 1'b1, 4'hE);
        run_interval(4'hF, 4'hE, 100, 1'b0, np, fp);
        check("R9 saturated longer", np, fp, 101);

        // R9: saturated count is not shorter than the maximum
        setup(8'h55, 1'b1, 2'd1, 63, 0, 1'b1, 1'b1, 4'hE);
        run_interval(4'hF, 4'hE, 100, 1'b0, np, fp);
        check("R9 saturated shorter", np, fp, 0);

        // R10: stretch running across reset is ignored
        setup(8'h55, 1'b1, 2'd0, 0, 0, 1'b1, 1'b1, 4'hE);
        @(negedge clk);
        chan_in = 4'hF;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        np = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (trig_out) np++;
            if (i == 3) chan_in = 4'hE;
        end
        check("R10 reset mid-stretch", np, 0, 0);

        // R10: stretch opened while disabled is ignored after enable rises
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        chan_in = 4'hF;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        np = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (trig_out) np++;
            if (i == 3) chan_in = 4'hE;
        end
        check("R10 enabled mid-stretch", np, 0, 0);

        // R10: next fresh stretch is measured again
        run_interval(4'hF, 4'hE, 2, 1'b0, np, fp);
        check("R10 fresh stretch", np, fp, 3);

        // R8: gate goes inactive on the closing edge
        setup(8'h55, 1'b1, 2'd0, 1, 0, 1'b1, 1'b1, 4'hE);
        run_interval(4'hF, 4'hE, 4, 1'b1, np, fp);
        check("R8 gate lost at close", np, fp, 0);

        // R8: gate becomes active on the closing edge
        setup(8'h55, 1'b1, 2'd0, 1, 0, 1'b0, 1'b1, 4'hE);
        run_interval(4'hF, 4'hE, 4, 1'b1, np, fp);
        check("R8 gate gained at close", np, fp, 5);

        // R7: timeout event dropped by gate is not retried
        setup(8'h55, 1'b1, 2'd3, 2, 0, 1'b0, 1'b1, 4'hE);
        @(negedge clk);
        chan_in = 4'hF;
        np = 0;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            if (trig_out) np++;
            if (i == 4) gate_in = 1'b1;
            if (i == 8) chan_in = 4'hE;
        end
        check("R7 dropped timeout", np, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule